// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the control and status registers of an ECC memory controller. Software reaches nine 32-bit word registers through a simple request interface with one-cycle read latency. The registers are enable, delay, fault status, slot configuration, two fault-address words, a diagnostic word and two event counters. A fault-capture port lets the ECC datapath record an error. It updates the status flags, latches the two fault-address words and, when interrupts are enabled, raises an interrupt line that stays high until software writes the fault status register.

A static implementation code (`IMPL`) and version code (`VER`) select the variant. Implementation 0 is the basic variant. It stores only a few enable bits, keeps its refresh-enable bit across a soft reset, and also decodes a four-byte diagnostic byte window. Implementations 1 and 2 are the extended variants. They store a wider enable field, always force the implementation and version code into the top byte of the enable register, and keep that byte and the SIMM enables across a soft reset.

`rst_n` is the asynchronous power-on reset. `soft_rst` is a synchronous controller reset that rewrites only selected state.

Top module: `memctl_csr_bank`

## Requirements
- R1: After power-on reset the register values are as follows. Enable (word 0) reads {IMPL[3:0], VER[3:0], 24'h0}. Delay (word 1) reads 0x00000020. Fault address 0 (word 4) reads 0x07C00000. Fault status (2), slot configuration (3), fault address 1 (5), diagnostic word (6) and the event counters (7, 8) read 0. `irq` is 0.
- R2: On the basic variant (IMPL=0), a write to word 0 stores `wdata & 0x00000103`. No version or implementation bits are forced in.
- R3: On an extended variant (IMPL≠0), a write to word 0 stores `(wdata & 0x00000BFF) | {IMPL, VER, 24'h0}`. Bit 1 of word 0 is the interrupt enable.
- R4: A write to word 1 stores `wdata & 0x7FFFFFFF`, so bit 31 always reads 0.
- R5: A cycle with `soft_rst` high has the following effects.
  - Words 1, 2, 3, 4, 5, 7 and 8 take their R1 values and `irq` drops.
  - Word 0 keeps only bit 8 on the basic variant, and keeps bits 31:24 and 9:2 on extended variants.
  - The diagnostic word and the diagnostic byte window are left unchanged.
  - Bus writes in that cycle are discarded.
- R6: A `flt_valid` cycle updates fault status as follows. Bit 0 is ORed with `flt_ce` and bit 3 with `flt_ue`. Bits 7:4 load `flt_dw` and bits 15:8 load `flt_synd`. The same cycle loads words 4 and 5 from `flt_addr0` and `flt_addr1`.
- R7: A fault arriving while status bit 0 or bit 3 is already set also sets bit 16 (multiple errors). Otherwise bit 16 keeps its value.
- R8: A fault raises `irq` on the next cycle only if word 0 bit 1 is 1. With that bit at 0, `irq` keeps its value.
- R9: A bus write to word 2 stores the written value and drives `irq` to 0 on the next cycle.
- R10: When a fault and a bus write to word 2 fall in the same cycle, the fault update wins and the written value is discarded.
- R11: Words 4 and 5 are read-only from the bus. Writes to them do not change their values.
- R12: The diagnostic byte window is selected with `bus_diag=1`. On the basic variant it holds 4 bytes indexed by `bus_addr[1:0]`. A write stores `wdata[7:0]` and a read returns the byte zero-extended. On extended variants, window reads return 0 and window writes have no effect.
- R13: Words 3, 6, 7 and 8 store all 32 bits independently of one another. Reads of word indices 9 to 15 return 0.
- R14: A read request (`bus_valid=1`, `bus_write=0`) gives `bus_rvalid=1` with `bus_rdata` on the following cycle. `bus_rvalid` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst | input | 1 | Synchronous controller reset (selective) |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_diag | input | 1 | 1 = diagnostic byte window, 0 = word registers |
| bus_addr | input | 4 | Word index, or byte index in its low bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| flt_valid | input | 1 | Fault capture strobe |
| flt_ce | input | 1 | Correctable error flag |
| flt_ue | input | 1 | Uncorrectable error flag |
| flt_dw | input | 4 | Double-word index of the fault |
| flt_synd | input | 8 | Syndrome of the fault |
| flt_addr0 | input | 32 | Value for fault address word 0 |
| flt_addr1 | input | 32 | Value for fault address word 1 |
| irq | output | 1 | Interrupt, level |

## Verification
The bench drives two instances side by side, an extended variant with a nonzero version code and a basic variant. Values differ per variant on every enable write and soft reset. A design that forced the version on the basic part, or dropped it on the extended part, fails at once.

The bench sends a second fault after a first one to catch the multiple-error bit. A design that set it unconditionally, or ignored the earlier flag, would read the wrong status. It also collides a status write with a fault, where a design that let the write win would lose the fault record and drop the interrupt. A fault with interrupts disabled shows whether `irq` is gated.

The soft reset is applied while a delay write is in flight and while the interrupt is high. A design that cleared the kept enable fields, wiped the diagnostic bytes, or accepted the write would read back wrong values.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

  localparam int REG_W = 32;

  // Word indices (software-visible ordering)
  localparam logic [3:0] IDX_ENABLE  = 4'd0;
  localparam logic [3:0] IDX_DELAY   = 4'd1;
  localparam logic [3:0] IDX_FSTAT   = 4'd2;
  localparam logic [3:0] IDX_SLOTCFG = 4'd3;
  localparam logic [3:0] IDX_FADDR0  = 4'd4;
  localparam logic [3:0] IDX_FADDR1  = 4'd5;
  localparam logic [3:0] IDX_DIAGW   = 4'd6;
  localparam logic [3:0] IDX_EVCNT0  = 4'd7;
  localparam logic [3:0] IDX_EVCNT1  = 4'd8;

  // Enable register masks
  localparam logic [REG_W-1:0] EN_WMASK_BASIC = 32'h0000_0103;
  localparam logic [REG_W-1:0] EN_WMASK_EXT   = 32'h0000_0BFF;
  localparam logic [REG_W-1:0] EN_KEEP_BASIC  = 32'h0000_0100;
  localparam logic [REG_W-1:0] EN_KEEP_EXT    = 32'hFF00_03FC;
  localparam int               EN_IRQ_EN_BIT  = 1;

  // Delay register
  localparam logic [REG_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;
  localparam logic [REG_W-1:0] DELAY_INIT  = 32'h0000_0020;

  // Fault address word 0 init
  localparam logic [REG_W-1:0] FADDR0_INIT = 32'h07C0_0000;

  // Fault status bit positions
  localparam int FS_CE_BIT  = 0;
  localparam int FS_UE_BIT  = 3;
  localparam int FS_DW_LSB  = 4;
  localparam int FS_SY_LSB  = 8;
  localparam int FS_ME_BIT  = 16;

  typedef struct packed {
    logic             ce;
    logic             ue;
    logic [3:0]       dw;
    logic [7:0]       synd;
    logic [REG_W-1:0] addr0;
    logic [REG_W-1:0] addr1;
  } fault_rec_t;

endpackage

// File: rtl/memctl_enable_reg.sv
module memctl_enable_reg
  import memctl_csr_pkg::*;
#(
  parameter int IMPL = 0,
  parameter int VER  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);

  localparam logic [REG_W-1:0] ID_VAL = {4'(IMPL), 4'(VER), 24'h0};

  logic [REG_W-1:0] wr_val;
  logic [REG_W-1:0] keep_mask;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] en_q;

  generate
    if (IMPL == 0) begin : g_basic
      assign wr_val    = wdata & EN_WMASK_BASIC;
      assign keep_mask = EN_KEEP_BASIC;
    end else begin : g_ext
      assign wr_val    = (wdata & EN_WMASK_EXT) | ID_VAL;
      assign keep_mask = EN_KEEP_EXT;
    end
  endgenerate

  always_comb begin
    en_d = en_q;
    if (soft_rst)   en_d = en_q & keep_mask;
    else if (wr_en) en_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= ID_VAL;
    else        en_q <= en_d;
  end

  assign q = en_q;

  localparam logic [REG_W-1:0] CHK_MASK  = (IMPL == 0) ? EN_WMASK_BASIC : EN_WMASK_EXT;
  localparam logic [REG_W-1:0] CHK_FORCE = (IMPL == 0) ? '0 : ID_VAL;
  localparam logic [REG_W-1:0] CHK_KEEP  = (IMPL == 0) ? EN_KEEP_BASIC : EN_KEEP_EXT;

  assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> (q == (($past(wdata) & CHK_MASK) | CHK_FORCE)));

  assert_enable_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (q == ($past(q) & CHK_KEEP)));

endmodule

// File: rtl/memctl_fault_capture.sv
module memctl_fault_capture
  import memctl_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             flt_valid,
  input  fault_rec_t       flt,
  input  logic             int_en,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] addr0_q,
  output logic [REG_W-1:0] addr1_q,
  output logic             irq_q
);

  logic [REG_W-1:0] stat_d;
  logic [REG_W-1:0] addr0_d;
  logic [REG_W-1:0] addr1_d;
  logic             irq_d;
  logic             err_seen;

  assign err_seen = stat_q[FS_CE_BIT] | stat_q[FS_UE_BIT];

  always_comb begin
    stat_d  = stat_q;
    addr0_d = addr0_q;
    addr1_d = addr1_q;
    irq_d   = irq_q;
    if (soft_rst) begin
      stat_d  = '0;
      addr0_d = FADDR0_INIT;
      addr1_d = '0;
      irq_d   = 1'b0;
    end else if (flt_valid) begin
      stat_d[FS_CE_BIT]              = stat_q[FS_CE_BIT] | flt.ce;
      stat_d[FS_UE_BIT]              = stat_q[FS_UE_BIT] | flt.ue;
      stat_d[FS_DW_LSB +: 4]         = flt.dw;
      stat_d[FS_SY_LSB +: 8]         = flt.synd;
      stat_d[FS_ME_BIT]              = stat_q[FS_ME_BIT] | err_seen;
      addr0_d                        = flt.addr0;
      addr1_d                        = flt.addr1;
      irq_d                          = irq_q | int_en;
    end else if (wr_stat) begin
      stat_d = wdata;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      addr0_q <= FADDR0_INIT;
      addr1_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      addr0_q <= addr0_d;
      addr1_q <= addr1_d;
      irq_q   <= irq_d;
    end
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(flt_valid && int_en && !soft_rst));

  assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !flt_valid && !soft_rst) |=> !irq_q);

  assert_multi_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !soft_rst && (stat_q[FS_CE_BIT] || stat_q[FS_UE_BIT])) |=> stat_q[FS_ME_BIT]);

  assert_addr_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_valid && !soft_rst) |=> ($stable(addr0_q) && $stable(addr1_q)));

  assert_fault_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && wr_stat && !soft_rst) |=> (stat_q[FS_SY_LSB +: 8] == $past(flt.synd)));

endmodule

// File: rtl/memctl_diag_window.sv
module memctl_diag_window #(
  parameter int IMPL  = 0,
  parameter int BYTES = 4,
  localparam int IW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte
);

  generate
    if (IMPL == 0) begin : g_present
      logic [7:0] mem_q [BYTES];
      logic [7:0] mem_d [BYTES];

      always_comb begin
        for (int i = 0; i < BYTES; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[idx] = wbyte;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < BYTES; i++) mem_q[i] <= '0;
        end else begin
          for (int i = 0; i < BYTES; i++) mem_q[i] <= mem_d[i];
        end
      end

      assign rbyte = mem_q[idx];

      assert_diag_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(idx)] == $past(wbyte)));
    end else begin : g_absent
      logic unused_diag;
      assign unused_diag = ^{wr_en, idx, wbyte, clk, rst_n};
      assign rbyte = 8'h00;
    end
  endgenerate

endmodule

// File: rtl/memctl_csr_bank.sv
module memctl_csr_bank
  import memctl_csr_pkg::*;
#(
  parameter int IMPL       = 0,
  parameter int VER        = 0,
  parameter int DIAG_BYTES = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_diag,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              flt_valid,
  input  logic              flt_ce,
  input  logic              flt_ue,
  input  logic [3:0]        flt_dw,
  input  logic [7:0]        flt_synd,
  input  logic [31:0]       flt_addr0,
  input  logic [31:0]       flt_addr1,
  output logic              irq
);

  localparam int DIW = $clog2(DIAG_BYTES);

  logic wr_word, wr_byte, rd_req;
  logic wr_en_reg, wr_delay, wr_stat, wr_slot, wr_diagw, wr_ev0, wr_ev1;

  assign wr_word = bus_valid && bus_write && !bus_diag && !soft_rst;
  assign wr_byte = bus_valid && bus_write &&  bus_diag && !soft_rst;
  assign rd_req  = bus_valid && !bus_write;

  assign wr_en_reg = wr_word && (bus_addr == ADDR_W'(IDX_ENABLE));
  assign wr_delay  = wr_word && (bus_addr == ADDR_W'(IDX_DELAY));
  assign wr_stat   = wr_word && (bus_addr == ADDR_W'(IDX_FSTAT));
  assign wr_slot   = wr_word && (bus_addr == ADDR_W'(IDX_SLOTCFG));
  assign wr_diagw  = wr_word && (bus_addr == ADDR_W'(IDX_DIAGW));
  assign wr_ev0    = wr_word && (bus_addr == ADDR_W'(IDX_EVCNT0));
  assign wr_ev1    = wr_word && (bus_addr == ADDR_W'(IDX_EVCNT1));

  // Enable register
  logic [31:0] enable_q;
  memctl_enable_reg #(.IMPL(IMPL), .VER(VER)) u_enable (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en_reg), .wdata(bus_wdata), .q(enable_q)
  );

  // Fault status / address / interrupt
  fault_rec_t  flt_rec;
  logic [31:0] stat_q, faddr0_q, faddr1_q;
  assign flt_rec = '{ce: flt_ce, ue: flt_ue, dw: flt_dw, synd: flt_synd,
                     addr0: flt_addr0, addr1: flt_addr1};

  memctl_fault_capture u_fault (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .flt_valid(flt_valid), .flt(flt_rec),
    .int_en(enable_q[EN_IRQ_EN_BIT]),
    .wr_stat(wr_stat), .wdata(bus_wdata),
    .stat_q(stat_q), .addr0_q(faddr0_q), .addr1_q(faddr1_q), .irq_q(irq)
  );

  // Diagnostic byte window
  logic [7:0] diag_rbyte;
  memctl_diag_window #(.IMPL(IMPL), .BYTES(DIAG_BYTES)) u_diag (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_byte),
    .idx(bus_addr[DIW-1:0]), .wbyte(bus_wdata[7:0]), .rbyte(diag_rbyte)
  );

  // Plain storage registers
  logic [31:0] delay_q, slot_q, diagw_q, ev0_q, ev1_q;
  logic [31:0] delay_d, slot_d, diagw_d, ev0_d, ev1_d;

  always_comb begin
    delay_d = delay_q;
    slot_d  = slot_q;
    diagw_d = diagw_q;
    ev0_d   = ev0_q;
    ev1_d   = ev1_q;
    if (soft_rst) begin
      delay_d = DELAY_INIT;
      slot_d  = '0;
      ev0_d   = '0;
      ev1_d   = '0;
    end else begin
      if (wr_delay) delay_d = bus_wdata & DELAY_WMASK;
      if (wr_slot)  slot_d  = bus_wdata;
      if (wr_diagw) diagw_d = bus_wdata;
      if (wr_ev0)   ev0_d   = bus_wdata;
      if (wr_ev1)   ev1_d   = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= DELAY_INIT;
      slot_q  <= '0;
      diagw_q <= '0;
      ev0_q   <= '0;
      ev1_q   <= '0;
    end else begin
      delay_q <= delay_d;
      slot_q  <= slot_d;
      diagw_q <= diagw_d;
      ev0_q   <= ev0_d;
      ev1_q   <= ev1_d;
    end
  end

  // Read path
  logic [31:0] rd_word, rdata_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    rd_word = '0;
    unique case (bus_addr)
      ADDR_W'(IDX_ENABLE):  rd_word = enable_q;
      ADDR_W'(IDX_DELAY):   rd_word = delay_q;
      ADDR_W'(IDX_FSTAT):   rd_word = stat_q;
      ADDR_W'(IDX_SLOTCFG): rd_word = slot_q;
      ADDR_W'(IDX_FADDR0):  rd_word = faddr0_q;
      ADDR_W'(IDX_FADDR1):  rd_word = faddr1_q;
      ADDR_W'(IDX_DIAGW):   rd_word = diagw_q;
      ADDR_W'(IDX_EVCNT0):  rd_word = ev0_q;
      ADDR_W'(IDX_EVCNT1):  rd_word = ev1_q;
      default:              rd_word = '0;
    endcase
    rdata_d = rdata_q;
    if (rd_req) rdata_d = bus_diag ? {24'h0, diag_rbyte} : rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_req;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  assert_read_latency_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_no_spurious_rvalid_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  assert_undecoded_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !bus_diag && (bus_addr > ADDR_W'(IDX_EVCNT1))) |=> (bus_rdata == 32'h0));

  assert_delay_bit31_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_delay |=> !delay_q[31]);

endmodule

// File: tb/memctl_csr_bank_tb_top.sv
`timescale 1ns/1ps
module memctl_csr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst;
  logic        bus_valid, bus_write, bus_diag;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        flt_valid, flt_ce, flt_ue;
  logic [3:0]  flt_dw;
  logic [7:0]  flt_synd;
  logic [31:0] flt_addr0, flt_addr1;

  logic [31:0] rd_a, rd_b;
  logic        rv_a, rv_b, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] qa[$];
  logic [31:0] qb[$];
  string       qt[$];

  always #4 clk = ~clk;

  // Extended variant, implementation 1, version 3
  memctl_csr_bank #(.IMPL(1), .VER(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_diag(bus_diag),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .bus_rvalid(rv_a),
    .flt_valid(flt_valid), .flt_ce(flt_ce), .flt_ue(flt_ue),
    .flt_dw(flt_dw), .flt_synd(flt_synd),
    .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq_a)
  );

  // Basic variant, implementation 0, version 2
  memctl_csr_bank #(.IMPL(0), .VER(2)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_diag(bus_diag),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .bus_rvalid(rv_b),
    .flt_valid(flt_valid), .flt_ce(flt_ce), .flt_ue(flt_ue),
    .flt_dw(flt_dw), .flt_synd(flt_synd),
    .flt_addr0(flt_addr0), .flt_addr1(flt_addr1), .irq(irq_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items as read data appears
  always @(negedge clk) begin
    if (rst_n && (rv_a || rv_b)) begin
      if (qa.size() == 0) begin
        check("R14 unexpected rvalid", 32'(rv_a), 32'h0);
      end else begin
        logic [31:0] ea, eb;
        string t;
        ea = qa.pop_front();
        eb = qb.pop_front();
        t  = qt.pop_front();
        check({t, " [impl1]"}, rd_a, ea);
        check({t, " [impl0]"}, rd_b, eb);
      end
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge
  task automatic rd(input logic diag, input logic [3:0] a, input logic [31:0] ea,
                    input logic [31:0] eb, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_diag = diag; bus_addr = a;
    qa.push_back(ea); qb.push_back(eb); qt.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic diag, input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_diag = diag; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic fault(input logic ce, input logic ue, input logic [3:0] dw,
                       input logic [7:0] sy, input logic [31:0] a0, input logic [31:0] a1);
    flt_valid = 1'b1; flt_ce = ce; flt_ue = ue; flt_dw = dw; flt_synd = sy;
    flt_addr0 = a0; flt_addr1 = a1;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic ea, input logic eb, input string tag);
    check({tag, " irq [impl1]"}, 32'(irq_a), 32'(ea));
    check({tag, " irq [impl0]"}, 32'(irq_b), 32'(eb));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_diag = 1'b0; bus_addr = '0; bus_wdata = '0;
    flt_valid = 1'b0; flt_ce = 1'b0; flt_ue = 1'b0; flt_dw = '0; flt_synd = '0;
    flt_addr0 = '0; flt_addr1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 power-on values
    chk_irq(1'b0, 1'b0, "R1");
    check("R14 idle rvalid", 32'(rv_a), 32'h0);
    rd(0, 4'd0, 32'h1300_0000, 32'h0200_0000, "R1 enable");
    rd(0, 4'd1, 32'h20, 32'h20, "R1 delay");
    rd(0, 4'd2, 0, 0, "R1 status");
    rd(0, 4'd3, 0, 0, "R1 slot");
    rd(0, 4'd4, 32'h07C0_0000, 32'h07C0_0000, "R1 faddr0");
    rd(0, 4'd5, 0, 0, "R1 faddr1");
    rd(0, 4'd6, 0, 0, "R1 diagword");
    rd(0, 4'd7, 0, 0, "R1 ev0");
    rd(0, 4'd8, 0, 0, "R1 ev1");

    // R2 / R3 enable write masking
    wr(0, 4'd0, 32'hFFFF_FFFF);
    rd(0, 4'd0, 32'h1300_0BFF, 32'h0000_0103, "R2 R3 enable all ones");
    wr(0, 4'd0, 32'h0000_0A55);
    rd(0, 4'd0, 32'h1300_0A55, 32'h0000_0001, "R2 R3 enable pattern");

    // R4 delay
    wr(0, 4'd1, 32'hFFFF_FFFF);
    rd(0, 4'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4 delay all ones");
    wr(0, 4'd1, 32'h8000_0001);
    rd(0, 4'd1, 32'h1, 32'h1, "R4 delay bit31");

    // R13 plain registers and undecoded
    wr(0, 4'd3, 32'hDEAD_BEEF);
    wr(0, 4'd6, 32'h1234_5678);
    wr(0, 4'd7, 32'hA5A5_A5A5);
    wr(0, 4'd8, 32'h0F0F_0F0F);
    rd(0, 4'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R13 slot");
    rd(0, 4'd6, 32'h1234_5678, 32'h1234_5678, "R13 diagword");
    rd(0, 4'd7, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R13 ev0");
    rd(0, 4'd8, 32'h0F0F_0F0F, 32'h0F0F_0F0F, "R13 ev1");
    wr(0, 4'd9, 32'hFFFF_FFFF);
    rd(0, 4'd9, 0, 0, "R13 undecoded 9");
    rd(0, 4'd15, 0, 0, "R13 undecoded 15");

    // R11 fault address read-only
    wr(0, 4'd4, 32'h1111_1111);
    wr(0, 4'd5, 32'h2222_2222);
    rd(0, 4'd4, 32'h07C0_0000, 32'h07C0_0000, "R11 faddr0");
    rd(0, 4'd5, 0, 0, "R11 faddr1");

    // R6 / R8 fault with interrupts disabled (enable bit1 = 0)
    fault(1, 0, 4'd5, 8'h3C, 32'hCAFE_F00D, 32'h42);
    chk_irq(1'b0, 1'b0, "R8 gated");
    rd(0, 4'd2, 32'h3C51, 32'h3C51, "R6 status ce");
    rd(0, 4'd4, 32'hCAFE_F00D, 32'hCAFE_F00D, "R6 faddr0");
    rd(0, 4'd5, 32'h42, 32'h42, "R6 faddr1");

    // R7 / R8 second fault with interrupts enabled
    wr(0, 4'd0, 32'h3);
    fault(0, 1, 4'd2, 8'h81, 32'h1, 32'h2);
    chk_irq(1'b1, 1'b1, "R8 enabled");
    rd(0, 4'd2, 32'h0001_8129, 32'h0001_8129, "R7 multiple error");

    // R9 status write clears irq
    wr(0, 4'd2, 32'h0);
    chk_irq(1'b0, 1'b0, "R9");
    rd(0, 4'd2, 0, 0, "R9 status stored");
    fault(1, 0, 4'd0, 8'h00, 32'h3, 32'h4);
    chk_irq(1'b1, 1'b1, "R8 refire");
    rd(0, 4'd2, 32'h1, 32'h1, "R7 no multiple on clean");

    // R10 collision: fault and status write in one cycle
    flt_valid = 1'b1; flt_ce = 0; flt_ue = 1; flt_dw = 4'd7; flt_synd = 8'h55;
    flt_addr0 = 32'h5; flt_addr1 = 32'h6;
    wr(0, 4'd2, 32'hFFFF_FFFF);
    flt_valid = 1'b0;
    chk_irq(1'b1, 1'b1, "R10");
    rd(0, 4'd2, 32'h0001_5579, 32'h0001_5579, "R10 status");
    wr(0, 4'd2, 32'hABCD_0000);
    chk_irq(1'b0, 1'b0, "R9 value write");
    rd(0, 4'd2, 32'hABCD_0000, 32'hABCD_0000, "R9 value stored");

    // R12 diagnostic byte window
    wr(1, 4'd2, 32'h0000_005A);
    wr(1, 4'd0, 32'hFFFF_FFC3);
    rd(1, 4'd2, 0, 32'h5A, "R12 byte2");
    rd(1, 4'd0, 0, 32'hC3, "R12 byte0");
    rd(1, 4'd1, 0, 0, "R12 byte1");
    rd(1, 4'd3, 0, 0, "R12 byte3");
    rd(1, 4'd6, 0, 32'h5A, "R12 low index bits");
    rd(0, 4'd6, 32'h1234_5678, 32'h1234_5678, "R12 word untouched");

    // R5 soft reset with irq high and a colliding write
    wr(0, 4'd0, 32'hFFFF_FFFF);
    fault(1, 0, 4'd1, 8'h11, 32'h7, 32'h8);
    chk_irq(1'b1, 1'b1, "R5 pre");
    soft_rst = 1'b1;
    wr(0, 4'd1, 32'h0000_1234);
    soft_rst = 1'b0;
    chk_irq(1'b0, 1'b0, "R5");
    rd(0, 4'd0, 32'h1300_03FC, 32'h0000_0100, "R5 enable keep");
    rd(0, 4'd1, 32'h20, 32'h20, "R5 delay");
    rd(0, 4'd2, 0, 0, "R5 status");
    rd(0, 4'd3, 0, 0, "R5 slot");
    rd(0, 4'd4, 32'h07C0_0000, 32'h07C0_0000, "R5 faddr0");
    rd(0, 4'd5, 0, 0, "R5 faddr1");
    rd(0, 4'd6, 32'h1234_5678, 32'h1234_5678, "R5 diagword kept");
    rd(0, 4'd7, 0, 0, "R5 ev0");
    rd(0, 4'd8, 0, 0, "R5 ev1");
    rd(1, 4'd2, 0, 32'h5A, "R5 diag byte kept");

    repeat (3) @(negedge clk);
    check("R14 queue drained", 32'(qa.size()), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule